// File: doc/BRIEF.md
# Frame Size Statistics Counters

This block holds a bank of 32-bit traffic counters for an Ethernet-style MAC, with one set for the transmit direction and one for the receive direction. A direction signals that a frame has finished by raising a single-cycle done strobe together with the frame's byte length. On that cycle the direction's frame count and good-frame count each increase by one. Its byte count and good-byte count each increase by the length. Exactly one of eight length-class counters also increases by one.

Software reaches every counter through a word-indexed window inside a byte-addressed register space. Reads return the current count combinationally. A write replaces a counter's value, which is how software clears or presets it. Counter slots that hardware never updates, such as the error and drop slots, act as plain scratch registers that keep whatever software last wrote.

Top module: `frame_stat_bank`

## Requirements
- R1: Each finished frame increases exactly one length-class counter of its direction. The classes are: below 64 bytes, exactly 64, 65–127, 128–255, 256–511, 512–1023, 1024–2047, and 2048 or more. For transmit these are at indices 7, 10, 11, 12, 13, 14, 15 and 16. For receive they are at indices 39, 42, 43, 44, 45, 46, 47 and 48.
- R2: Each finished frame adds one to the frame count and to the good-frame count, and adds its length to the byte count and to the good-byte count. For transmit these are indices 1, 19, 17 and 29. For receive they are indices 33, 51, 49 and 56.
- R3: The window covers byte offsets 0x200 through 0x2E3. Counter index is (offset − 0x200) / 4, and offset bits [1:0] are ignored. `reg_rdata` shows the addressed counter in the same cycle, and shows 0 for any offset outside the window.
- R4: A write inside the window replaces the addressed counter's value. The new value is readable from the next cycle.
- R5: A write outside the window changes no counter.
- R6: Counter indices 0–56 that are not named in R1 or R2 are never changed by frame events; they change only by software write.
- R7: When a transmit frame and a receive frame finish in the same cycle, both sets of updates are applied.
- R8: Every counter wraps modulo 2^32.
- R9: When a software write and a frame update hit the same counter in the same cycle, the written value wins. The frame's other counter updates still take effect.
- R10: After reset every counter reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done | input | 1 | Transmit frame finished (one-cycle strobe) |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| rx_done | input | 1 | Receive frame finished (one-cycle strobe) |
| rx_len | input | LEN_W | Receive frame length in bytes |
| reg_addr | input | ADDR_W | Byte offset for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |

## Verification
Every frame event and every software write lands in the counters at the clock edge where it is sampled, so its effect is due one cycle later. Reads are combinational, with no added latency. The bench applies each stimulus before a rising edge and updates its reference model right after that edge. It then reads back through the window at the following falling edge, with the address settled, so each comparison falls in the first cycle where the new value is due.

// File: rtl/frame_stat_pkg.sv
`timescale 1ns/1ps
package frame_stat_pkg;
    localparam int CNT_W    = 32;
    localparam int NUM_CNT  = 57;
    localparam int IDX_W    = $clog2(NUM_CNT);
    localparam int NUM_BINS = 8;
    localparam int NUM_DIR  = 2;
    localparam int DIR_SPAN = 32;

    typedef enum logic [1:0] {K_PKT, K_OCT, K_OKF, K_OKO} kind_e;

    typedef struct packed {
        logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
    } state_t;

    // exclusive upper limit of length class k (class 7 is open ended)
    function automatic int bin_limit(input int k);
        if (k == 0)      return 64;
        else if (k == 1) return 65;
        else             return 1 << (k + 5);
    endfunction

    function automatic logic [IDX_W-1:0] bin_index(input int dir, input int k);
        int ofs;
        ofs = (k == 0) ? 7 : 9 + k;
        return IDX_W'(dir * DIR_SPAN + ofs);
    endfunction

    function automatic logic [IDX_W-1:0] kind_index(input int dir, input kind_e k);
        int ofs;
        case (k)
            K_PKT:   ofs = 1;
            K_OCT:   ofs = 17;
            K_OKF:   ofs = 19;
            default: ofs = (dir == 0) ? 29 : 24;
        endcase
        return IDX_W'(dir * DIR_SPAN + ofs);
    endfunction
endpackage

// File: rtl/frame_size_binner.sv
`timescale 1ns/1ps
module frame_size_binner
    import frame_stat_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0]    len,
    output logic [NUM_BINS-1:0] bin_oh
);
    always_comb begin
        logic found;
        bin_oh = '0;
        found  = 1'b0;
        for (int k = 0; k < NUM_BINS - 1; k++) begin
            if (!found && (32'(len) < bin_limit(k))) begin
                bin_oh[k] = 1'b1;
                found     = 1'b1;
            end
        end
        if (!found) bin_oh[NUM_BINS-1] = 1'b1;
    end
endmodule

// File: rtl/frame_stat_window.sv
`timescale 1ns/1ps
module frame_stat_window
    import frame_stat_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int WIN_BASE = 'h200
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int BASE_WORD = WIN_BASE / 4;

    logic [31:0] word;
    logic [31:0] ofs;

    always_comb begin
        word = 32'(addr[ADDR_W-1:2]);
        ofs  = word - 32'(BASE_WORD);
        hit  = (word >= 32'(BASE_WORD)) && (ofs < 32'(NUM_CNT));
        idx  = ofs[IDX_W-1:0];
    end
endmodule

// File: rtl/frame_stat_bank.sv
`timescale 1ns/1ps
module frame_stat_bank
    import frame_stat_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int ADDR_W   = 10,
    parameter int WIN_BASE = 'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_done,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic              rx_done,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata
);
    logic                               win_hit;
    logic [IDX_W-1:0]                   win_idx;
    logic [NUM_DIR-1:0]                 done;
    logic [NUM_DIR-1:0][LEN_W-1:0]      len;
    logic [NUM_DIR-1:0][NUM_BINS-1:0]   bin_oh;
    state_t                             st_d, st_q;

    assign done = {rx_done, tx_done};
    assign len  = {rx_len, tx_len};

    generate
        for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
            frame_size_binner #(.LEN_W(LEN_W)) u_bin (
                .len    (len[g]),
                .bin_oh (bin_oh[g])
            );
        end
    endgenerate

    frame_stat_window #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_win (
        .addr (reg_addr),
        .hit  (win_hit),
        .idx  (win_idx)
    );

    always_comb begin
        st_d = st_q;
        for (int d = 0; d < NUM_DIR; d++) begin
            if (done[d]) begin
                st_d.cnt[kind_index(d, K_PKT)] = st_d.cnt[kind_index(d, K_PKT)] + CNT_W'(1);
                st_d.cnt[kind_index(d, K_OKF)] = st_d.cnt[kind_index(d, K_OKF)] + CNT_W'(1);
                st_d.cnt[kind_index(d, K_OCT)] = st_d.cnt[kind_index(d, K_OCT)] + CNT_W'(len[d]);
                st_d.cnt[kind_index(d, K_OKO)] = st_d.cnt[kind_index(d, K_OKO)] + CNT_W'(len[d]);
                for (int k = 0; k < NUM_BINS; k++) begin
                    if (bin_oh[d][k])
                        st_d.cnt[bin_index(d, k)] = st_d.cnt[bin_index(d, k)] + CNT_W'(1);
                end
            end
        end
        if (reg_wr && win_hit)
            st_d.cnt[win_idx] = reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = win_hit ? st_q.cnt[win_idx] : '0;
endmodule

// File: rtl/frame_stat_check.sv
`timescale 1ns/1ps
module frame_stat_check
    import frame_stat_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             tx_done,
    input logic                             rx_done,
    input logic [LEN_W-1:0]                 rx_len,
    input logic                             reg_wr,
    input logic                             win_hit,
    input logic [IDX_W-1:0]                 win_idx,
    input logic [CNT_W-1:0]                 reg_wdata,
    input logic [NUM_CNT-1:0][CNT_W-1:0]    cnt,
    input logic [NUM_DIR-1:0][NUM_BINS-1:0] bin_oh
);
    logic sw_wr;
    assign sw_wr = reg_wr && win_hit;

    p_onehot_bin_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(bin_oh[0]) && $onehot(bin_oh[1]));

    p_tx_pkt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done && !(sw_wr && win_idx == IDX_W'(1))
        |=> cnt[1] == $past(cnt[1]) + 32'd1);

    p_rx_octets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && !(sw_wr && win_idx == IDX_W'(49))
        |=> cnt[49] == $past(cnt[49]) + 32'($past(rx_len)));

    p_sw_replace_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> cnt[$past(win_idx)] == $past(reg_wdata));

    p_outside_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !win_hit && !tx_done && !rx_done |=> $stable(cnt));

    p_reserved_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr |=> $stable(cnt[0]) && $stable(cnt[32]) && $stable(cnt[30]));
endmodule

bind frame_stat_bank frame_stat_check #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_done   (tx_done),
    .rx_done   (rx_done),
    .rx_len    (rx_len),
    .reg_wr    (reg_wr),
    .win_hit   (win_hit),
    .win_idx   (win_idx),
    .reg_wdata (reg_wdata),
    .cnt       (st_q.cnt),
    .bin_oh    (bin_oh)
);

// File: tb/frame_stat_bank_test.sv
`timescale 1ns/1ps
module frame_stat_bank_test;
    localparam int LEN_W  = 16;
    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tx_done = 1'b0;
    logic [LEN_W-1:0]  tx_len = '0;
    logic              rx_done = 1'b0;
    logic [LEN_W-1:0]  rx_len = '0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m [0:56];

    frame_stat_bank #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) uut (.*);

    always #2 clk = ~clk;

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog R10: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    function automatic int mbin(int base, int l);
        if (l < 64)        return base + 7;
        else if (l == 64)  return base + 10;
        else if (l < 128)  return base + 11;
        else if (l < 256)  return base + 12;
        else if (l < 512)  return base + 13;
        else if (l < 1024) return base + 14;
        else if (l < 2048) return base + 15;
        else               return base + 16;
    endfunction

    function automatic string req_of(int i);
        if (i == 7 || i == 39 || (i >= 10 && i <= 16) || (i >= 42 && i <= 48)) return "R1";
        if (i == 1 || i == 17 || i == 19 || i == 29 || i == 33 || i == 49 || i == 51 || i == 56)
            return "R2";
        return "R6";
    endfunction

    task automatic model(bit td, int tl, bit rd, int rl, bit w, int a, logic [31:0] d);
        if (td) begin
            m[1] += 1; m[19] += 1; m[17] += 32'(tl); m[29] += 32'(tl);
            m[mbin(0, tl)] += 1;
        end
        if (rd) begin
            m[33] += 1; m[51] += 1; m[49] += 32'(rl); m[56] += 32'(rl);
            m[mbin(32, rl)] += 1;
        end
        if (w && a >= 'h200 && a <= 'h2E3) m[(a - 'h200) / 4] = d;
    endtask

    task automatic step(bit td, int tl, bit rd, int rl, bit w, int a, logic [31:0] d);
        @(negedge clk);
        tx_done = td; tx_len = LEN_W'(tl);
        rx_done = rd; rx_len = LEN_W'(rl);
        reg_wr = w; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(posedge clk);
        model(td, tl, rd, rl, w, a, d);
        #1;
        tx_done = 0; rx_done = 0; reg_wr = 0;
    endtask

    task automatic rd_chk(string req, int a, logic [31:0] exp);
        @(negedge clk);
        reg_addr = ADDR_W'(a);
        #1;
        n_chk++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h: actual %h expected %h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic sweep(string tag);
        for (int i = 0; i < 57; i++) begin
            if (tag == "") rd_chk(req_of(i), 'h200 + 4 * i, m[i]);
            else           rd_chk(tag, 'h200 + 4 * i, m[i]);
        end
    endtask

    function automatic int pick_len();
        int edges [16] = '{0, 1, 63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 2047, 2048, 65535};
        if ($urandom % 2) return edges[$urandom % 16];
        return int'($urandom % 65536);
    endfunction

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 57; i++) m[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: all counters clear after reset
        sweep("R10");

        // R1 / R2: class edges on transmit
        step(1, 63, 0, 0, 0, 0, 0);
        step(1, 64, 0, 0, 0, 0, 0);
        step(1, 65, 0, 0, 0, 0, 0);
        rd_chk("R1", 'h200 + 4 * 7, 32'd1);
        rd_chk("R1", 'h200 + 4 * 10, 32'd1);
        rd_chk("R1", 'h200 + 4 * 11, 32'd1);
        rd_chk("R2", 'h200 + 4 * 1, 32'd3);
        rd_chk("R2", 'h200 + 4 * 29, 32'd192);

        // R1: receive upper classes
        step(0, 0, 1, 2048, 0, 0, 0);
        step(0, 0, 1, 2047, 0, 0, 0);
        rd_chk("R1", 'h200 + 4 * 48, 32'd1);
        rd_chk("R1", 'h200 + 4 * 47, 32'd1);
        rd_chk("R2", 'h200 + 4 * 56, 32'd4095);

        // R7: both directions in one cycle
        step(1, 100, 1, 300, 0, 0, 0);
        rd_chk("R7", 'h200 + 4 * 1, 32'd4);
        rd_chk("R7", 'h200 + 4 * 33, 32'd3);
        rd_chk("R7", 'h200 + 4 * 45, 32'd1);

        // R8: wrap of octet counter and packet counter
        step(0, 0, 0, 0, 1, 'h200 + 4 * 17, 32'hFFFF_FFFF);
        step(0, 0, 0, 0, 1, 'h200 + 4 * 33, 32'hFFFF_FFFF);
        step(1, 3, 1, 10, 0, 0, 0);
        rd_chk("R8", 'h200 + 4 * 17, 32'd2);
        rd_chk("R8", 'h200 + 4 * 33, 32'd0);

        // R9: write wins on the colliding counter only
        step(1, 70, 0, 0, 1, 'h200 + 4 * 1, 32'h55);
        rd_chk("R9", 'h200 + 4 * 1, 32'h55);
        rd_chk("R9", 'h200 + 4 * 19, m[19]);

        // R4 / R6: reserved slot takes a write, frames leave it alone
        step(0, 0, 0, 0, 1, 'h200 + 4 * 30, 32'hCAFE_0001);
        step(1, 500, 1, 900, 0, 0, 0);
        rd_chk("R4", 'h200 + 4 * 30, 32'hCAFE_0001);
        rd_chk("R6", 'h200 + 4 * 0, 32'd0);

        // R3: byte offset bits ignored, last word, outside reads zero
        rd_chk("R3", 'h200 + 4 * 30 + 3, 32'hCAFE_0001);
        rd_chk("R3", 'h2E0, m[56]);
        rd_chk("R3", 'h2E4, 32'd0);
        rd_chk("R3", 'h1FC, 32'd0);

        // R5: writes outside the window change nothing
        step(0, 0, 0, 0, 1, 'h1FC, 32'h1234_5678);
        step(0, 0, 0, 0, 1, 'h2E4, 32'h8765_4321);
        step(0, 0, 0, 0, 1, 'h100, 32'hDEAD_BEEF);
        sweep("R5");

        // random traffic mixed with writes
        for (int r = 0; r < 4; r++) begin
            for (int s = 0; s < 300; s++) begin
                bit w;
                int a;
                w = ($urandom % 8) == 0;
                a = ($urandom % 4 == 0) ? int'($urandom % 1024) : 'h200 + 4 * int'($urandom % 57);
                step(bit'($urandom % 2), pick_len(), bit'($urandom % 2), pick_len(), w, a, $urandom);
            end
            sweep("");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule